// File: doc/BRIEF.md
# Sequential Subkey Pair Generator

This block expands a cipher key of 128, 192 or 256 bits into the forty 32-bit subkeys used by a Twofish-style block cipher. It produces them as pairs: pair p yields subkey 2p (the upper output) and subkey 2p+1 (the lower output). Pairs 0 to 3 are the eight whitening keys, and pairs 4 to 19 are the round keys. A single key-dependent h-function unit is shared in time. Each pair takes two passes through it, one for the even-derived value and one for the odd-derived value.

Two run types are offered. A sequence run walks pairs 0 to 19 in ascending order, so that a consumer can write each pair into a small register file as it appears. A single run computes one pair chosen by an index input. The key, key length, run type and index are captured when a run is accepted. Later changes to these inputs do not disturb a run in progress.

Top module: `tfk_subkey_gen`

## Requirements
- R1: Key byte n sits at `key[255-8n -: 8]`. A 128-bit key uses bytes 0..15, a 192-bit key uses bytes 0..23 and a 256-bit key uses all 32. Word j is built little-endian from bytes 4j..4j+3, with byte 4j as the least significant byte. Words 0,2,4,6 feed the even h pass and words 1,3,5,7 feed the odd h pass.
- R2: `key_len` selects 0 = 128 bits, 1 = 192 bits, 2 = 256 bits. Code 3 is rejected: a start with it launches nothing and produces no `valid`.
- R3: Pair p computes A = h(byte 2p replicated into all four bytes, even words) and B = rotl8(h(byte 2p+1 replicated, odd words)). It outputs `k_even` = A+B and `k_odd` = rotl9(A+2B), both modulo 2^32. h applies the q0/q1 byte permutation layers in the order set by key length, then multiplies by the 4x4 MDS matrix over GF(2^8) with the reduction polynomial 0x169.
- R4: With `seq_mode`=1, an accepted start yields pairs 0,1,...,19 in order. The `valid` for pair p is high in the cycle that follows clock edge 2(p+1) after the edge that sampled `start`, so pulses come every second cycle.
- R5: With `seq_mode`=0, an accepted start yields exactly the one pair `pair_sel`, two edges after the start edge. A `pair_sel` of 20 or more rejects the start.
- R6: `done` is high for one cycle, together with the `valid` of the last pair of a run (pair 19 in a sequence run, the only pair in a single run).
- R7: While a run is in progress, `start` is ignored. Changes on `key`, `key_len`, `seq_mode` and `pair_sel` have no effect on that run.
- R8: Synchronous active-high reset aborts any run. It clears `valid`, `done`, `pair_out`, `k_even` and `k_odd` to zero.
- R9: `k_even`, `k_odd` and `pair_out` keep their values between `valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run when idle |
| seq_mode | input | 1 | 1 = walk all pairs, 0 = single pair |
| key_len | input | 2 | Key length code |
| pair_sel | input | IDX_W | Pair index for a single run |
| key | input | 256 | Key bytes, big-endian |
| k_even | output | 32 | Subkey 2p |
| k_odd | output | 32 | Subkey 2p+1 |
| pair_out | output | IDX_W | Index p of the presented pair |
| valid | output | 1 | One-cycle pulse per produced pair |
| done | output | 1 | Pulse with the last pair of a run |

## Verification
The bench tries the key expansion with three keys: all-zero, all-ones and an incrementing byte pattern. Each is tried at every key length. The zero key isolates the permutation and MDS path from the key words. The incrementing key exposes any byte or word misordering, since every byte differs. Single runs at pairs 0, 7 and 19 confirm that the index, and not the run position, picks the constants. Inputs are changed in the middle of a run, and starts are given with invalid codes, to separate latched state from live inputs.

// File: rtl/tfk_pkg.sv
package tfk_pkg;
  localparam int KEY_W   = 256;
  localparam int WORD_W  = 32;
  localparam int HALF_WD = KEY_W / (2 * WORD_W);

  typedef enum logic [1:0] {KL128 = 2'd0, KL192 = 2'd1, KL256 = 2'd2, KLBAD = 2'd3} klen_e;

  // nibble tables, entry i at bits [4i+3:4i]
  localparam logic [63:0] Q0_T0 = 64'h4ACE95B023F6D718;
  localparam logic [63:0] Q0_T1 = 64'hD9076A4F53218BCE;
  localparam logic [63:0] Q0_T2 = 64'h17423F8C09D6E5AB;
  localparam logic [63:0] Q0_T3 = 64'hAC5803B9E6214F7D;
  localparam logic [63:0] Q1_T0 = 64'h5CA04913E67FDB82;
  localparam logic [63:0] Q1_T1 = 64'h809F5AD673C4B2E1;
  localparam logic [63:0] Q1_T2 = 64'hF3B28DE0A96157C4;
  localparam logic [63:0] Q1_T3 = 64'hA802F746ED3C159B;

  function automatic logic [7:0] q_perm(input logic sel, input logic [7:0] x);
    logic [63:0] t0, t1, t2, t3;
    logic [3:0] a0, b0, a1, b1, a2, b2, a3, b3, a4, b4;
    t0 = sel ? Q1_T0 : Q0_T0;
    t1 = sel ? Q1_T1 : Q0_T1;
    t2 = sel ? Q1_T2 : Q0_T2;
    t3 = sel ? Q1_T3 : Q0_T3;
    a0 = x[7:4];
    b0 = x[3:0];
    a1 = a0 ^ b0;
    b1 = a0 ^ {b0[0], b0[3:1]} ^ {a0[0], 3'b000};
    a2 = t0[4*a1 +: 4];
    b2 = t1[4*b1 +: 4];
    a3 = a2 ^ b2;
    b3 = a2 ^ {b2[0], b2[3:1]} ^ {a2[0], 3'b000};
    a4 = t2[4*a3 +: 4];
    b4 = t3[4*b3 +: 4];
    return {b4, a4};
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ 8'h69) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // row r, column c at index 4r+c
  localparam logic [15:0][7:0] MDS_M = {
    8'h5B, 8'hEF, 8'h01, 8'hEF,
    8'hEF, 8'h01, 8'h5B, 8'hEF,
    8'h01, 8'hEF, 8'hEF, 8'h5B,
    8'h5B, 8'h5B, 8'hEF, 8'h01};
endpackage

// File: rtl/tfk_key_words.sv
module tfk_key_words
  import tfk_pkg::*;
(
  input  logic [KEY_W-1:0]                 key_be,
  output logic [HALF_WD-1:0][WORD_W-1:0]   even_w,
  output logic [HALF_WD-1:0][WORD_W-1:0]   odd_w
);
  localparam int NWORDS = KEY_W / WORD_W;
  localparam int NBYTES = WORD_W / 8;

  logic [NWORDS-1:0][WORD_W-1:0] word_le;

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign word_le[j][8*i +: 8] = key_be[KEY_W-1-8*(NBYTES*j+i) -: 8];
    end
  end

  for (genvar j = 0; j < HALF_WD; j++) begin : g_split
    assign even_w[j] = word_le[2*j];
    assign odd_w[j]  = word_le[2*j+1];
  end
endmodule

// File: rtl/tfk_h_unit.sv
module tfk_h_unit
  import tfk_pkg::*;
(
  input  logic [WORD_W-1:0]               x_in,
  input  logic [1:0]                      len_code,
  input  logic [HALF_WD-1:0][WORD_W-1:0]  lw,
  output logic [WORD_W-1:0]               h_out
);
  // bit j set selects q1 for byte lane j
  localparam logic [3:0] SEL_L3 = 4'b1001;
  localparam logic [3:0] SEL_L2 = 4'b0011;
  localparam logic [3:0] SEL_L1 = 4'b1010;
  localparam logic [3:0] SEL_L0 = 4'b1100;
  localparam logic [3:0] SEL_FN = 4'b0101;

  logic use_l3, use_l2;
  logic [3:0][7:0] y;

  assign use_l3 = (len_code == KL256);
  assign use_l2 = (len_code == KL256) || (len_code == KL192);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [7:0] s3, s2, s1, s0;
    assign s3   = use_l3 ? (q_perm(SEL_L3[j], x_in[8*j +: 8]) ^ lw[3][8*j +: 8]) : x_in[8*j +: 8];
    assign s2   = use_l2 ? (q_perm(SEL_L2[j], s3) ^ lw[2][8*j +: 8]) : s3;
    assign s1   = q_perm(SEL_L1[j], s2) ^ lw[1][8*j +: 8];
    assign s0   = q_perm(SEL_L0[j], s1) ^ lw[0][8*j +: 8];
    assign y[j] = q_perm(SEL_FN[j], s0);
  end

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      h_out[8*r +: 8] = '0;
      for (int c = 0; c < 4; c++)
        h_out[8*r +: 8] = h_out[8*r +: 8] ^ gf_mul(MDS_M[4*r+c], y[c]);
    end
  end
endmodule

// File: rtl/tfk_pair_mix.sv
module tfk_pair_mix
  import tfk_pkg::*;
(
  input  logic [WORD_W-1:0] a_val,
  input  logic [WORD_W-1:0] h_odd,
  output logic [WORD_W-1:0] sk_even,
  output logic [WORD_W-1:0] sk_odd
);
  logic [WORD_W-1:0] b_rot, sum2;
  assign b_rot   = {h_odd[23:0], h_odd[31:24]};
  assign sk_even = a_val + b_rot;
  assign sum2    = a_val + {b_rot[30:0], 1'b0};
  assign sk_odd  = {sum2[22:0], sum2[31:23]};
endmodule

// File: rtl/tfk_subkey_gen.sv
module tfk_subkey_gen
  import tfk_pkg::*;
#(
  parameter int NPAIRS = 20,
  parameter int IDX_W  = $clog2(NPAIRS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              seq_mode,
  input  logic [1:0]        key_len,
  input  logic [IDX_W-1:0]  pair_sel,
  input  logic [KEY_W-1:0]  key,
  output logic [WORD_W-1:0] k_even,
  output logic [WORD_W-1:0] k_odd,
  output logic [IDX_W-1:0]  pair_out,
  output logic              valid,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(NPAIRS - 1);

  logic                              busy, phase, seq_r;
  logic [1:0]                        len_r;
  logic [KEY_W-1:0]                  key_r;
  logic [IDX_W-1:0]                  pair_r;
  logic [WORD_W-1:0]                 a_r, h_val, mix_e, mix_o;
  logic [HALF_WD-1:0][WORD_W-1:0]    ev_w, od_w, sel_w;
  logic [7:0]                        idx_byte;
  logic                              accept;

  assign accept = !busy && start && (key_len != KLBAD) &&
                  (seq_mode || (pair_sel <= LAST_PAIR));

  tfk_key_words u_words (.key_be(key_r), .even_w(ev_w), .odd_w(od_w));

  assign idx_byte = 8'({pair_r, phase});
  assign sel_w    = phase ? od_w : ev_w;

  tfk_h_unit u_h (
    .x_in    ({4{idx_byte}}),
    .len_code(len_r),
    .lw      (sel_w),
    .h_out   (h_val)
  );

  tfk_pair_mix u_mix (.a_val(a_r), .h_odd(h_val), .sk_even(mix_e), .sk_odd(mix_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      seq_r    <= 1'b0;
      len_r    <= KL128;
      key_r    <= '0;
      pair_r   <= '0;
      a_r      <= '0;
      k_even   <= '0;
      k_odd    <= '0;
      pair_out <= '0;
      valid    <= 1'b0;
      done     <= 1'b0;
    end else begin
      valid <= 1'b0;
      done  <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy   <= 1'b1;
          phase  <= 1'b0;
          seq_r  <= seq_mode;
          len_r  <= key_len;
          key_r  <= key;
          pair_r <= seq_mode ? '0 : pair_sel;
        end
      end else if (!phase) begin
        a_r   <= h_val;
        phase <= 1'b1;
      end else begin
        k_even   <= mix_e;
        k_odd    <= mix_o;
        pair_out <= pair_r;
        valid    <= 1'b1;
        phase    <= 1'b0;
        if (seq_r && (pair_r != LAST_PAIR)) begin
          pair_r <= pair_r + 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tfk_subkey_gen_chk.sv
module tfk_subkey_gen_chk #(
  parameter int NPAIRS = 20,
  parameter int IDX_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic             done,
  input logic [IDX_W-1:0] pair_out,
  input logic [31:0]      k_even,
  input logic [31:0]      k_odd
);
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> valid);                                                   // R6
  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);                                                 // R4
  AST_PAIR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(pair_out) < NPAIRS));                              // R5
  AST_PAIR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (valid && !done) |-> ##2 (valid && (pair_out == $past(pair_out, 2) + 1'b1))); // R4
  AST_HOLD_KEYS: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(k_even) && $stable(k_odd) && $stable(pair_out)) || valid); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && !done));                                 // R8
endmodule

bind tfk_subkey_gen tfk_subkey_gen_chk #(.NPAIRS(NPAIRS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .done(done),
  .pair_out(pair_out), .k_even(k_even), .k_odd(k_odd));

// File: tb/tb_tfk_subkey_gen.sv
module tb_tfk_subkey_gen;
  localparam int NP = 20;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            seq_mode = 1'b0;
  logic [1:0]      key_len = 2'd0;
  logic [IW-1:0]   pair_sel = '0;
  logic [255:0]    key_i = '0;
  logic [31:0]     k_even, k_odd;
  logic [IW-1:0]   pair_out;
  logic            valid, done;

  always #10 clk = ~clk;

  tfk_subkey_gen #(.NPAIRS(NP), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .start(start), .seq_mode(seq_mode), .key_len(key_len),
    .pair_sel(pair_sel), .key(key_i), .k_even(k_even), .k_odd(k_odd),
    .pair_out(pair_out), .valid(valid), .done(done));

  int n_checks = 0, n_fail = 0, g_valid = 0, g_done = 0, cyc = 0;
  bit cmp_en = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int QT [2][4][16] = '{
    '{'{'h8,'h1,'h7,'hD,'h6,'hF,'h3,'h2,'h0,'hB,'h5,'h9,'hE,'hC,'hA,'h4},
      '{'hE,'hC,'hB,'h8,'h1,'h2,'h3,'h5,'hF,'h4,'hA,'h6,'h7,'h0,'h9,'hD},
      '{'hB,'hA,'h5,'hE,'h6,'hD,'h9,'h0,'hC,'h8,'hF,'h3,'h2,'h4,'h7,'h1},
      '{'hD,'h7,'hF,'h4,'h1,'h2,'h6,'hE,'h9,'hB,'h3,'h0,'h8,'h5,'hC,'hA}},
    '{'{'h2,'h8,'hB,'hD,'hF,'h7,'h6,'hE,'h3,'h1,'h9,'h4,'h0,'hA,'hC,'h5},
      '{'h1,'hE,'h2,'hB,'h4,'hC,'h3,'h7,'h6,'hD,'hA,'h5,'hF,'h9,'h0,'h8},
      '{'h4,'hC,'h7,'h5,'h1,'h6,'h9,'hA,'h0,'hE,'hD,'h8,'h2,'hB,'h3,'hF},
      '{'hB,'h9,'h5,'h1,'hC,'h3,'hD,'hE,'h6,'h4,'h7,'hF,'h2,'h0,'h8,'hA}}};

  function automatic int ror4(input int v);
    return ((v >> 1) | ((v & 1) << 3)) & 15;
  endfunction

  function automatic int rq(input int w, input int x);
    int a, b, a2, b2, a3, b3;
    a  = (x >> 4) & 15;
    b  = x & 15;
    a2 = QT[w][0][a ^ b];
    b2 = QT[w][1][a ^ ror4(b) ^ ((a << 3) & 15)];
    a3 = a2 ^ b2;
    b3 = a2 ^ ror4(b2) ^ ((a2 << 3) & 15);
    return (QT[w][3][b3] << 4) | QT[w][2][a3];
  endfunction

  function automatic int gm(input int a, input int b);
    int p = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) p = p ^ (a << i);
    for (int i = 15; i >= 8; i--) if ((p >> i) & 1) p = p ^ ('h169 << (i - 8));
    return p & 255;
  endfunction

  function automatic logic [31:0] ref_h(input logic [31:0] x, input logic [31:0] l [4], input int len);
    int y0, y1, y2, y3, z0, z1, z2, z3;
    y0 = x[7:0]; y1 = x[15:8]; y2 = x[23:16]; y3 = x[31:24];
    if (len == 2) begin
      y0 = rq(1, y0) ^ l[3][7:0];  y1 = rq(0, y1) ^ l[3][15:8];
      y2 = rq(0, y2) ^ l[3][23:16]; y3 = rq(1, y3) ^ l[3][31:24];
    end
    if (len >= 1) begin
      y0 = rq(1, y0) ^ l[2][7:0];  y1 = rq(1, y1) ^ l[2][15:8];
      y2 = rq(0, y2) ^ l[2][23:16]; y3 = rq(0, y3) ^ l[2][31:24];
    end
    y0 = rq(1, rq(0, rq(0, y0) ^ l[1][7:0])   ^ l[0][7:0]);
    y1 = rq(0, rq(0, rq(1, y1) ^ l[1][15:8])  ^ l[0][15:8]);
    y2 = rq(1, rq(1, rq(0, y2) ^ l[1][23:16]) ^ l[0][23:16]);
    y3 = rq(0, rq(1, rq(1, y3) ^ l[1][31:24]) ^ l[0][31:24]);
    z0 = y0 ^ gm('hEF, y1) ^ gm('h5B, y2) ^ gm('h5B, y3);
    z1 = gm('h5B, y0) ^ gm('hEF, y1) ^ gm('hEF, y2) ^ y3;
    z2 = gm('hEF, y0) ^ gm('h5B, y1) ^ y2 ^ gm('hEF, y3);
    z3 = gm('hEF, y0) ^ y1 ^ gm('hEF, y2) ^ gm('h5B, y3);
    return {z3[7:0], z2[7:0], z1[7:0], z0[7:0]};
  endfunction

  // R1 R3: expected pair from key bytes
  function automatic void ref_pair(input logic [255:0] k, input int len, input int p,
                                   output logic [31:0] ke, output logic [31:0] ko);
    logic [31:0] m [8];
    logic [31:0] ev [4];
    logic [31:0] od [4];
    logic [31:0] a, b, t;
    for (int w = 0; w < 8; w++)
      m[w] = {k[255-8*(4*w+3) -: 8], k[255-8*(4*w+2) -: 8], k[255-8*(4*w+1) -: 8], k[255-8*(4*w) -: 8]};
    for (int w = 0; w < 4; w++) begin
      ev[w] = m[2*w];
      od[w] = m[2*w+1];
    end
    a  = ref_h((2*p) * 32'h01010101, ev, len);
    b  = ref_h((2*p+1) * 32'h01010101, od, len);
    b  = {b[23:0], b[31:24]};
    ke = a + b;
    t  = a + 2 * b;
    ko = {t[22:0], t[31:23]};
  endfunction

  bit m_busy = 0, m_ph = 0, m_seq = 0;
  int m_len = 0, m_pair = 0;
  logic [255:0] m_key = '0;
  logic [31:0] e_ke = '0, e_ko = '0;
  int e_pair = 0;
  bit e_valid = 0, e_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_ph = 0; m_pair = 0;
      e_ke = '0; e_ko = '0; e_pair = 0; e_valid = 0; e_done = 0;
    end else begin
      e_valid = 0; e_done = 0;
      if (m_busy) begin
        if (!m_ph) m_ph = 1;
        else begin
          ref_pair(m_key, m_len, m_pair, e_ke, e_ko);
          e_valid = 1; e_pair = m_pair; m_ph = 0;
          if (m_seq && m_pair < NP - 1) m_pair++;
          else begin m_busy = 0; e_done = 1; end
        end
      end else if (start && key_len != 2'd3 && (seq_mode || int'(pair_sel) < NP)) begin
        m_busy = 1; m_ph = 0; m_seq = seq_mode; m_len = key_len; m_key = key_i;
        m_pair = seq_mode ? 0 : int'(pair_sel);
      end
    end
    cmp_en = 1;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_en) begin
      chk({valid, done} == {e_valid, e_done}, "R4 R5 R6 valid/done", {62'd0, valid, done}, {62'd0, e_valid, e_done});
      chk({k_even, k_odd} == {e_ke, e_ko}, "R1 R3 R9 subkeys", {k_even, k_odd}, {e_ke, e_ko});
      chk(int'(pair_out) == e_pair, "R4 R9 pair_out", 64'(pair_out), 64'(e_pair));
      if (valid) g_valid++;
      if (done) g_done++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic kick(input logic [255:0] k, input logic [1:0] l, input bit sq, input int ps);
    @(negedge clk);
    key_i = k; key_len = l; seq_mode = sq; pair_sel = IW'(ps); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
  endtask

  logic [255:0] kz, k1, kinc;

  initial begin
    int v0, d0;
    logic [31:0] hold_e;
    kz = '0;
    k1 = '1;
    for (int i = 0; i < 32; i++) kinc[255-8*i -: 8] = 8'(i * 7 + 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && !done && k_even == 0 && k_odd == 0 && pair_out == 0, "R8 reset state",
        {k_even, k_odd}, 64'd0);

    // sequence runs over keys and lengths
    for (int l = 0; l < 3; l++) begin
      for (int kk = 0; kk < 3; kk++) begin
        v0 = g_valid; d0 = g_done;
        kick(kk == 0 ? kz : (kk == 1 ? k1 : kinc), 2'(l), 1'b1, 0);
        wait_done();
        chk(g_valid - v0 == NP, "R4 pairs per sequence run", 64'(g_valid - v0), 64'(NP));
        chk(g_done - d0 == 1, "R6 one done per run", 64'(g_done - d0), 64'd1);
      end
    end

    // single runs
    for (int s = 0; s < 3; s++) begin
      int ps;
      ps = (s == 0) ? 0 : ((s == 1) ? 7 : 19);
      v0 = g_valid;
      kick(kinc, 2'd2, 1'b0, ps);
      wait_done();
      chk(g_valid - v0 == 1, "R5 single pair count", 64'(g_valid - v0), 64'd1);
      chk(int'(pair_out) == ps, "R5 selected pair", 64'(pair_out), 64'(ps));
    end

    // out-of-range index rejected, outputs held
    hold_e = k_even;
    v0 = g_valid;
    kick(k1, 2'd0, 1'b0, 25);
    repeat (8) @(negedge clk);
    chk(g_valid == v0, "R5 index 25 rejected", 64'(g_valid - v0), 64'd0);
    chk(k_even == hold_e, "R9 hold after rejected start", 64'(k_even), 64'(hold_e));

    // length code 3 rejected
    v0 = g_valid;
    kick(kinc, 2'd3, 1'b1, 0);
    repeat (8) @(negedge clk);
    chk(g_valid == v0, "R2 code 3 rejected", 64'(g_valid - v0), 64'd0);

    // inputs changed mid-run
    v0 = g_valid; d0 = g_done;
    kick(kinc, 2'd1, 1'b1, 0);
    repeat (3) @(negedge clk);
    key_i = k1; key_len = 2'd2; seq_mode = 1'b0; pair_sel = 5'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(g_valid - v0 == NP, "R7 run unaffected by restart", 64'(g_valid - v0), 64'(NP));
    chk(g_done - d0 == 1, "R7 single done", 64'(g_done - d0), 64'd1);

    // reset aborts a run
    kick(kz, 2'd0, 1'b1, 0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && pair_out == 0 && k_even == 0, "R8 reset clears outputs", {k_even, 27'd0, pair_out, valid}, 64'd0);
    v0 = g_valid;
    repeat (10) @(negedge clk);
    chk(g_valid == v0, "R8 run aborted", 64'(g_valid - v0), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule